// File: doc/BRIEF.md
# Pipelined Word CRC-32 Engine

This block computes a 32-bit cyclic redundancy remainder for each 32-bit data word it receives, treating every word independently. The word is first combined with the all-ones seed, then put through 32 shift-and-reduce bit-steps. Those steps are split across a chain of registered stages, so that each clock period holds only a short run of XOR logic instead of one deep combinational tree.

A single parameter sets how many bit-steps each stage performs: 1, 4, 8 or 32. The stage count, and with it the latency, follows from that choice. The computed value is identical for every setting. The input side takes one word per clock through a valid/data pair, and the output side presents each result through a valid/result pair in arrival order. There is no backpressure, and no remainder is carried from one word to the next.

Top module: `crc32_word_pipe`

## Requirements
- R1: Synchronous active-high reset clears every stage's valid flag. While reset is high, and after it until a new word is accepted, `out_valid` stays 0, including for words offered while reset was high.
- R2: The result is the remainder of the 32-bit word, most significant bit first, with generator 0x04C11DB7, seed 0xFFFFFFFF, no bit reflection and no final XOR. Word 0xFFFFFFFF yields 0x00000000, and word 0xFFFFFFFE yields 0x04C11DB7.
- R3: With S = STEPS_PER_STAGE and N = 32/S stages, a word sampled at rising edge k appears with `out_valid` = 1 after rising edge k+N-1, which is N clocks after it was presented.
- R4: A word can be accepted on every clock. A back-to-back stream produces back-to-back results in the same order, with none lost or duplicated.
- R5: For S = 1, 4, 8 and 32, every result is bit-identical to the bit-serial reference, including for all-zero, all-ones and alternating-bit words.
- R6: A clock with `in_valid` = 0 produces exactly one clock with `out_valid` = 0, N clocks later. Gaps in the input pattern appear unchanged in the output pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The word on `in_word` is offered this clock |
| in_word | input | 32 | Data word to be checksummed |
| out_valid | output | 1 | `out_crc` holds a finished result |
| out_crc | output | 32 | Remainder for the matching input word |

## Verification
The bench drives four copies of the engine, one for each steps-per-stage setting, with the same stimulus. It compares every output cycle against a bit-serial model and a per-copy latency schedule. The directed cases are chosen to catch specific faults. The all-ones word reduces to zero and the word one below it reduces to the generator, so a wrong seed, a wrong polynomial or reflected bit order gives a visibly different value. A single isolated word catches an off-by-one in latency, because the result appears one clock early or late in that copy only. Back-to-back and randomly gapped streams catch a stage that loads data only on some cycles, drops valid bits, or repeats a word; these show up as missing, duplicated or shifted result slots. Offering words while reset is high catches reset logic that clears data but lets a stale valid flag leak out.

// File: rtl/crc32p_pkg.sv
package crc32p_pkg;

   localparam int unsigned CRC_W = 32;

   typedef logic [CRC_W-1:0] crc_word_t;

   // one shift-and-reduce step, MSB first
   function automatic crc_word_t crc_bit_step(input crc_word_t v, input crc_word_t poly);
      crc_word_t sh;
      sh = {v[CRC_W-2:0], 1'b0};
      return v[CRC_W-1] ? (sh ^ poly) : sh;
   endfunction

   function automatic bit steps_legal(input int unsigned s);
      return (s == 1) || (s == 4) || (s == 8) || (s == 32);
   endfunction

endpackage

// File: rtl/crc32p_stepnet.sv
module crc32p_stepnet
   import crc32p_pkg::*;
#(
   parameter int unsigned STEPS = 8,
   parameter logic [31:0] POLY  = 32'h04C1_1DB7
) (
   input  crc_word_t acc_in,
   output crc_word_t acc_out
);

   crc_word_t chain [STEPS+1];

   assign chain[0] = acc_in;

   genvar g;
   generate
      for (g = 0; g < STEPS; g++) begin : g_step
         assign chain[g+1] = crc_bit_step(chain[g], POLY);
      end
   endgenerate

   assign acc_out = chain[STEPS];

endmodule

// File: rtl/crc32p_stage.sv
module crc32p_stage
   import crc32p_pkg::*;
#(
   parameter int unsigned STEPS = 8,
   parameter logic [31:0] POLY  = 32'h04C1_1DB7
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      vld_in,
   input  crc_word_t acc_in,
   output logic      vld_out,
   output crc_word_t acc_out
);

   crc_word_t next_acc;
   logic      vld_q;
   crc_word_t acc_q;

   crc32p_stepnet #(.STEPS(STEPS), .POLY(POLY)) u_net (
      .acc_in  (acc_in),
      .acc_out (next_acc)
   );

   // valid flag: reset to empty
   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_in;
   end

   // working value: no reset, loads only with a valid word
   always_ff @(posedge clk) begin
      if (vld_in) acc_q <= next_acc;
   end

   assign vld_out = vld_q;
   assign acc_out = acc_q;

   // R3: an accepted word advances exactly one stage per clock
   p_valid_advance_r3: assert property (@(posedge clk) disable iff (rst)
      (vld_in && !rst) |=> vld_out);

   // R6: an empty slot stays empty as it moves down the chain
   p_gap_advance_r6: assert property (@(posedge clk) disable iff (rst)
      (!vld_in && !rst) |=> !vld_out);

   // R2: a zero working value stays zero through any number of steps
   p_zero_fixed_r2: assert property (@(posedge clk) disable iff (rst)
      (vld_in && !rst && acc_in == '0) |=> (acc_out == '0));

endmodule

// File: rtl/crc32_word_pipe.sv
module crc32_word_pipe
   import crc32p_pkg::*;
#(
   parameter int unsigned STEPS_PER_STAGE = 8,
   parameter logic [31:0] POLY            = 32'h04C1_1DB7,
   parameter logic [31:0] INIT            = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        in_valid,
   input  logic [31:0] in_word,
   output logic        out_valid,
   output logic [31:0] out_crc
);

   localparam int unsigned NSTG  = CRC_W / STEPS_PER_STAGE;
   localparam int unsigned CNT_W = $clog2(NSTG + 2) + 1;

   initial begin
      assert (steps_legal(STEPS_PER_STAGE))
         else $error("STEPS_PER_STAGE must be 1, 4, 8 or 32");
   end

   logic      vld_c [NSTG+1];
   crc_word_t acc_c [NSTG+1];

   // seed combine ahead of the first stage
   assign vld_c[0] = in_valid;
   assign acc_c[0] = in_word ^ INIT;

   genvar s;
   generate
      for (s = 0; s < NSTG; s++) begin : g_stage
         crc32p_stage #(.STEPS(STEPS_PER_STAGE), .POLY(POLY)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .vld_in  (vld_c[s]),
            .acc_in  (acc_c[s]),
            .vld_out (vld_c[s+1]),
            .acc_out (acc_c[s+1])
         );
      end
   endgenerate

   assign out_valid = vld_c[NSTG];
   assign out_crc   = acc_c[NSTG];

   // words in flight between the ports
   logic [CNT_W-1:0] inflight_q;

   always_ff @(posedge clk) begin
      if (rst) inflight_q <= '0;
      else     inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
   end

   // R4: never more words held than stages, so nothing piles up or is lost
   p_inflight_bound_r4: assert property (@(posedge clk) disable iff (rst)
      inflight_q <= CNT_W'(NSTG));

   // R1: no result emerges unless a word was accepted after reset
   p_no_phantom_r1: assert property (@(posedge clk) disable iff (rst)
      (inflight_q == '0) |-> !out_valid);

endmodule

// File: tb/crc32_word_pipe_test.sv
`timescale 1ns/1ps
module crc32_word_pipe_test;

   localparam int NL = 4;
   localparam logic [31:0] GEN = 32'h04C1_1DB7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        ov [NL];
   logic [31:0] oc [NL];

   int   lat [NL] = '{32, 8, 4, 1};
   logic        expv [NL][64];
   logic [31:0] expd [NL][64];
   int   rx [NL];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   mon_en = 1'b0;
   string cur_req = "R1";
   logic [31:0] seed = 32'h1357_9BDF;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   crc32_word_pipe #(.STEPS_PER_STAGE(1)) u_s1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(ov[0]), .out_crc(oc[0]));
   crc32_word_pipe #(.STEPS_PER_STAGE(4)) u_s4 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(ov[1]), .out_crc(oc[1]));
   crc32_word_pipe #(.STEPS_PER_STAGE(8)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(ov[2]), .out_crc(oc[2]));
   crc32_word_pipe #(.STEPS_PER_STAGE(32)) u_s32 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(ov[3]), .out_crc(oc[3]));

   function automatic logic [31:0] ref_crc(input logic [31:0] w);
      logic [31:0] t;
      t = w ^ 32'hFFFF_FFFF;
      for (int i = 0; i < 32; i++) begin
         if (t[31]) t = (t << 1) ^ GEN;
         else       t = t << 1;
      end
      return t;
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // output monitor: sampled at the falling edge
   always @(negedge clk) begin
      if (mon_en) begin
         for (int l = 0; l < NL; l++) begin
            automatic int sl = cyc % 64;
            checks++;
            if (expv[l][sl]) begin
               if (ov[l] !== 1'b1 || oc[l] !== expd[l][sl]) begin
                  errors++;
                  $display("FAIL %s lane %0d cyc %0d: valid %b crc %h, expected valid 1 crc %h",
                           cur_req, l, cyc, ov[l], oc[l], expd[l][sl]);
               end
               rx[l]++;
               expv[l][sl] = 1'b0;
            end else if (ov[l] !== 1'b0) begin
               errors++;
               $display("FAIL %s lane %0d cyc %0d: valid %b, expected valid 0",
                        cur_req, l, cyc, ov[l]);
            end
         end
      end
   end

   task automatic drive(input logic v, input logic [31:0] d);
      @(posedge clk);
      #1;
      in_valid = v;
      in_word  = d;
      if (v && !rst) begin
         for (int l = 0; l < NL; l++) begin
            expv[l][(cyc + lat[l]) % 64] = 1'b1;
            expd[l][(cyc + lat[l]) % 64] = ref_crc(d);
         end
      end
   endtask

   task automatic drain_and_count(input int sent, input int base [NL]);
      for (int i = 0; i < 36; i++) drive(1'b0, 32'h0);
      for (int l = 0; l < NL; l++) begin
         checks++;
         if (rx[l] - base[l] != sent) begin
            errors++;
            $display("FAIL %s lane %0d: received %0d words, expected %0d",
                     cur_req, l, rx[l] - base[l], sent);
         end
      end
   endtask

   // R1: words offered during reset never emerge
   task automatic t_reset;
      int base [NL];
      cur_req = "R1";
      base = rx;
      @(posedge clk); #1;
      rst = 1'b1;
      drive(1'b1, 32'hDEAD_BEEF);
      mon_en = 1'b1;
      drive(1'b1, 32'h0000_0001);
      drive(1'b1, 32'hFFFF_FFFE);
      @(posedge clk); #1;
      rst = 1'b0;
      in_valid = 1'b0;
      drain_and_count(0, base);
   endtask

   // R2: known remainders for fixed words
   task automatic t_known;
      int base [NL];
      logic [31:0] w [4] = '{32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0000, 32'h8000_0000};
      cur_req = "R2";
      base = rx;
      checks++;
      if (ref_crc(32'hFFFF_FFFE) !== GEN || ref_crc(32'hFFFF_FFFF) !== 32'h0) begin
         errors++;
         $display("FAIL R2 model: got %h/%h, expected %h/0", ref_crc(32'hFFFF_FFFE),
                  ref_crc(32'hFFFF_FFFF), GEN);
      end
      for (int i = 0; i < 4; i++) begin
         drive(1'b1, w[i]);
         drive(1'b0, 32'h0);
         drive(1'b0, 32'h0);
      end
      drain_and_count(4, base);
   endtask

   // R3: a single isolated word, exact latency per lane
   task automatic t_latency;
      int base [NL];
      cur_req = "R3";
      base = rx;
      drive(1'b1, 32'h1234_5678);
      drain_and_count(1, base);
   endtask

   // R4: long back-to-back stream
   task automatic t_stream;
      int base [NL];
      cur_req = "R4";
      base = rx;
      for (int i = 0; i < 48; i++) begin
         seed = next_rand(seed);
         drive(1'b1, seed);
      end
      drain_and_count(48, base);
   endtask

   // R6: random gaps in the valid pattern
   task automatic t_gaps;
      int base [NL];
      int sent = 0;
      cur_req = "R6";
      base = rx;
      for (int i = 0; i < 80; i++) begin
         seed = next_rand(seed);
         drive(seed[7], seed);
         if (seed[7]) sent++;
      end
      drain_and_count(sent, base);
   endtask

   // R5: edge patterns, identical across all step settings
   task automatic t_equal;
      int base [NL];
      logic [31:0] w [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA,
                             32'h5555_5555, 32'h0000_0001, 32'h7FFF_FFFF};
      cur_req = "R5";
      base = rx;
      for (int i = 0; i < 6; i++) drive(1'b1, w[i]);
      drain_and_count(6, base);
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin
         rx[l] = 0;
         for (int k = 0; k < 64; k++) begin
            expv[l][k] = 1'b0;
            expd[l][k] = '0;
         end
      end
      t_reset();
      t_known();
      t_latency();
      t_stream();
      t_gaps();
      t_equal();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule